// File: doc/BRIEF.md
# Dual-Enable Asynchronous Static RAM Functional Model

This block is a synthesizable, cycle-based stand-in for an 8K-word by 8-bit asynchronous static RAM. It is meant to be instantiated as the target memory inside testbenches for SRAM controllers. The model takes a word address and four control strobes: an active-low select, an active-high select, an active-low write strobe and an active-low read-drive strobe. From these it works out one of four modes (standby, write, read, output deselect), stores data and returns it.

The bidirectional data pins of a real device are split into three signals: a write-data input, a read-data output and a flag. The flag tells the surrounding bench when the model would be driving the bus. Read data follows the address and control inputs combinationally, as an asynchronous part would. Writes are committed on the rising edge of the model clock.

Internally, the 8,192 bytes are packed four to a row. A per-row "written" bit gives every location a defined value of 0x00 after reset, without clearing the array itself.

Top module: `sram_async_model`

## Requirements
- R1: The device is selected only when `ce_lo_n` is 0 and `ce_hi` is 1. Every other combination of the two selects is standby.
- R2: In standby, `rd_drive` is 0 and no write happens, whatever `wr_n` and `rd_n` are. Contents are unchanged afterwards.
- R3: When selected with `wr_n` = 0, the byte on `wr_data` is written to `addr` at the next rising clock edge, for both values of `rd_n`. During that cycle `rd_drive` is 0.
- R4: When selected with `wr_n` = 1 and `rd_n` = 0, `rd_drive` is 1 and `rd_data` shows the stored byte at `addr` in the same cycle, with no clock edge needed.
- R5: When selected with `wr_n` = 1 and `rd_n` = 1 (output deselect), `rd_drive` is 0 and no write happens.
- R6: A byte written in one cycle is returned by a read of the same address in the very next cycle.
- R7: After reset (`rst_n` low), every address reads 0x00 until it is written, including addresses written before the reset.
- R8: Stored bytes are kept across any number of standby and output-deselect cycles.
- R9: A write changes only the addressed byte. The other bytes that share its storage row (addresses that differ only in bits 1:0) keep their values.
- R10: Whenever `rd_drive` is 0, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; marks all rows unwritten |
| addr | input | 13 | Word address |
| ce_lo_n | input | 1 | Active-low device select |
| ce_hi | input | 1 | Active-high device select |
| wr_n | input | 1 | Active-low write strobe; takes priority over `rd_n` |
| rd_n | input | 1 | Active-low read-drive strobe |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte read; 0x00 when not driving |
| rd_drive | output | 1 | High when the model drives the data bus |

## Verification
The assertions take for granted that the control and address inputs hold steady across each rising clock edge and change only between edges, as a cycle-based controller drives them. They also assume no X values reach the select and strobe pins after reset. The stimulus keeps to this by changing every input on the falling edge and observing outputs shortly after, well before the next commit edge. Every select combination is visited. Every address is written and read back with an arithmetic pattern.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

   typedef enum logic [1:0] {
      MODE_STANDBY  = 2'd0,
      MODE_WRITE    = 2'd1,
      MODE_READ     = 2'd2,
      MODE_DESELECT = 2'd3
   } sram_mode_e;

   function automatic sram_mode_e classify(input logic selected,
                                           input logic wr_n,
                                           input logic rd_n);
      sram_mode_e m;
      if (!selected)   m = MODE_STANDBY;
      else if (!wr_n)  m = MODE_WRITE;
      else if (!rd_n)  m = MODE_READ;
      else             m = MODE_DESELECT;
      return m;
   endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_model_pkg::*;
#(
   parameter bit DUAL_ENABLE = 1'b1
) (
   input  logic       ce_lo_n,
   input  logic       ce_hi,
   input  logic       wr_n,
   input  logic       rd_n,
   output sram_mode_e mode,
   output logic       wr_en,
   output logic       rd_en
);

   logic selected;

   generate
      if (DUAL_ENABLE) begin : g_dual
         assign selected = !ce_lo_n && ce_hi;
      end else begin : g_single
         logic unused_hi;
         assign unused_hi = ce_hi;
         assign selected  = !ce_lo_n;
      end
   endgenerate

   always_comb begin
      mode  = classify(selected, wr_n, rd_n);
      wr_en = (mode == MODE_WRITE);
      rd_en = (mode == MODE_READ);
   end

endmodule

// File: rtl/sram_lane_store.sv
module sram_lane_store #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [LANES*DATA_W-1:0]  row_word,
   output logic                     row_written
);

   localparam int LANE_W = $clog2(LANES);
   localparam int ROW_W  = ADDR_W - LANE_W;
   localparam int ROWS   = 1 << ROW_W;
   localparam int ROW_BITS = LANES * DATA_W;

   generate
      if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
         $error("sram_lane_store: LANES must be a power of two, at least 2");
      end
      if (ROW_W < 1) begin : g_bad_addr
         $error("sram_lane_store: ADDR_W too small for LANES");
      end
   endgenerate

   logic [ROW_BITS-1:0] mem [ROWS];
   logic [ROWS-1:0]     written_q;
   logic [ROW_W-1:0]    row_idx;
   logic [LANE_W-1:0]   lane_idx;
   logic [ROW_BITS-1:0] row_base;
   logic [ROW_BITS-1:0] row_next;

   assign row_idx     = addr[ADDR_W-1:LANE_W];
   assign lane_idx    = addr[LANE_W-1:0];
   assign row_word    = mem[row_idx];
   assign row_written = written_q[row_idx];
   assign row_base    = row_written ? row_word : '0;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign row_next[g*DATA_W +: DATA_W] =
            (lane_idx == LANE_W'(g)) ? wr_data : row_base[g*DATA_W +: DATA_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[row_idx] <= row_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     written_q <= '0;
      else if (wr_en) written_q[row_idx] <= 1'b1;
   end

   // R8: without a write, the written-row map never changes
   a_r8_map_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(written_q));

   // R3: a write always leaves its row marked as written
   a_r3_row_marked: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> written_q[$past(row_idx)]);

endmodule

// File: rtl/sram_read_path.sv
module sram_read_path #(
   parameter int DATA_W = 8,
   parameter int LANES  = 4
) (
   input  logic [LANES*DATA_W-1:0] row_word,
   input  logic                    row_written,
   input  logic [$clog2(LANES)-1:0] lane_idx,
   input  logic                    rd_en,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    rd_drive
);

   logic [DATA_W-1:0] lane_val [LANES];
   logic [DATA_W-1:0] picked;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_pick
         assign lane_val[g] = row_word[g*DATA_W +: DATA_W];
      end
   endgenerate

   assign picked   = row_written ? lane_val[lane_idx] : '0;
   assign rd_drive = rd_en;
   assign rd_data  = rd_en ? picked : '0;

   always_comb begin
      // R10: data is held at zero whenever the bus is released
      a_r10_released_zero: assert (rd_drive || rd_data == '0);
   end

endmodule

// File: rtl/sram_async_model.sv
module sram_async_model
   import sram_model_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int DATA_W      = 8,
   parameter int LANES       = 4,
   parameter bit DUAL_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_lo_n,
   input  logic              ce_hi,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive
);

   localparam int LANE_W = $clog2(LANES);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("sram_async_model: DATA_W must be positive");
      end
   endgenerate

   sram_mode_e              mode;
   logic                    wr_en;
   logic                    rd_en;
   logic [LANES*DATA_W-1:0] row_word;
   logic                    row_written;
   logic                    unused_mode;

   assign unused_mode = ^mode;

   sram_mode_decode #(.DUAL_ENABLE(DUAL_ENABLE)) u_decode (
      .ce_lo_n (ce_lo_n),
      .ce_hi   (ce_hi),
      .wr_n    (wr_n),
      .rd_n    (rd_n),
      .mode    (mode),
      .wr_en   (wr_en),
      .rd_en   (rd_en)
   );

   sram_lane_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (addr),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .row_word    (row_word),
      .row_written (row_written)
   );

   sram_read_path #(.DATA_W(DATA_W), .LANES(LANES)) u_read (
      .row_word    (row_word),
      .row_written (row_written),
      .lane_idx    (addr[LANE_W-1:0]),
      .rd_en       (rd_en),
      .rd_data     (rd_data),
      .rd_drive    (rd_drive)
   );

   // R3: the bus is never driven while the write strobe is active and selected
   a_r3_no_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_lo_n && ce_hi && !wr_n) |-> !rd_drive);

   // R2: standby never drives the bus
   a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_lo_n || !ce_hi) |-> !rd_drive);

   // R6: a read right after a write to the same address returns that byte
   a_r6_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en ##1 (rd_en && addr == $past(addr))) |-> rd_data == $past(wr_data));

   // R4: a held read of a held address without a write returns a steady byte
   a_r4_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en) && $stable(addr)) |-> $stable(rd_data));

endmodule

// File: tb/sram_async_model_tb.sv
module sram_async_model_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [12:0] addr = '0;
   logic       ce_lo_n = 1'b1;
   logic       ce_hi = 1'b0;
   logic       wr_n = 1'b1;
   logic       rd_n = 1'b1;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rd_drive;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sram_async_model u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi),
      .wr_n(wr_n), .rd_n(rd_n), .wr_data(wr_data), .rd_data(rd_data),
      .rd_drive(rd_drive)
   );

   function automatic logic [7:0] pat(input int a, input int gen);
      return 8'(((a * 37) + (a >> 5) + gen * 91) ^ 8'h5A);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic cl, input logic ch, input logic w, input logic r,
                        input int a, input logic [7:0] d);
      @(negedge clk);
      ce_lo_n = cl; ce_hi = ch; wr_n = w; rd_n = r;
      addr = 13'(a); wr_data = d;
      #1;
   endtask

   task automatic do_write(input int a, input logic [7:0] d, input logic r);
      apply(1'b0, 1'b1, 1'b0, r, a, d);
      if (rd_drive !== 1'b0) check("R3 drive during write", {7'b0, rd_drive}, 8'h00);
   endtask

   task automatic read_chk(input string req, input int a, input logic [7:0] exp);
      apply(1'b0, 1'b1, 1'b1, 1'b0, a, 8'hC3);
      check(req, {7'b0, rd_drive}, 8'h01);
      check(req, rd_data, exp);
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst_n = 1'b0; ce_lo_n = 1'b1; ce_hi = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // reset state: released bus (R10, R2)
      repeat (3) @(negedge clk);
      #1;
      check("R10 reset rd_data", rd_data, 8'h00);
      check("R2 reset rd_drive", {7'b0, rd_drive}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // R7: every address reads zero before any write
      for (int a = 0; a < 8192; a++) read_chk("R7 unwritten zero", a, 8'h00);

      // R3: full write sweep, rd_n alternating to show write priority
      for (int a = 0; a < 8192; a++) do_write(a, pat(a, 0), 1'(a & 1));
      compared++;

      // R4/R9: read every address back, whole rows filled lane by lane
      for (int a = 0; a < 8192; a++) read_chk("R4 R9 readback", a, pat(a, 0));

      // R1/R2: each non-selecting combination with write and read strobes active
      for (int c = 0; c < 3; c++) begin
         logic cl, ch;
         cl = (c == 0) ? 1'b1 : (c == 1) ? 1'b1 : 1'b0;
         ch = (c == 0) ? 1'b0 : (c == 1) ? 1'b1 : 1'b0;
         for (int s = 0; s < 4; s++) begin
            apply(cl, ch, 1'(s >> 1), 1'(s & 1), 100 + c, 8'hEE);
            check("R1 R2 standby rd_drive", {7'b0, rd_drive}, 8'h00);
            check("R10 standby rd_data", rd_data, 8'h00);
         end
      end
      for (int c = 0; c < 3; c++)
         read_chk("R2 R8 kept across standby", 100 + c, pat(100 + c, 0));

      // R5: output deselect releases the bus and writes nothing
      apply(1'b0, 1'b1, 1'b1, 1'b1, 200, 8'h11);
      check("R5 deselect rd_drive", {7'b0, rd_drive}, 8'h00);
      check("R10 deselect rd_data", rd_data, 8'h00);
      repeat (5) apply(1'b0, 1'b1, 1'b1, 1'b1, 200, 8'h22);
      read_chk("R5 R8 no write in deselect", 200, pat(200, 0));

      // R6/R9: back-to-back write then read; neighbours in the row untouched
      for (int a = 4096; a < 4160; a++) begin
         do_write(a, pat(a, 1), 1'b0);
         read_chk("R6 next-cycle read", a, pat(a, 1));
         if ((a & 3) != 3)
            read_chk("R9 neighbour kept", a + 1, pat(a + 1, 0));
      end

      // R7: reset forgets earlier writes
      pulse_reset();
      read_chk("R7 after reset", 0, 8'h00);
      read_chk("R7 after reset", 4100, 8'h00);
      read_chk("R7 after reset", 8191, 8'h00);

      // R9/R7: single byte into a fresh row leaves its neighbours at zero
      do_write(17, 8'hA5, 1'b1);
      read_chk("R9 fresh row target", 17, 8'hA5);
      read_chk("R9 fresh row neighbour", 16, 8'h00);
      read_chk("R9 fresh row neighbour", 18, 8'h00);
      read_chk("R9 fresh row neighbour", 19, 8'h00);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule